// File: doc/BRIEF.md
# Partitioned Shared Register Address Mapper

This block turns the register operand address of one lane into a physical row of a register space shared by every wavefront of a SIMD engine. The space is split into three regions that sit back to back from row 0 upward. First comes a shared region that all wavefronts can reach. Next comes a clause-temporary region, stored as two copies: one copy serves the even wavefronts and the other serves the odd wavefronts. Last comes the private rows, which are handed out to each wavefront from a base row.

Every operand carries its own addressing mode, so a single instruction can mix shared rows with rows that belong to its own wavefront. In absolute mode the address is used as a row of the shared and temporary area. Indexed mode first adds an offset, taken either from the instruction or from an index register. Private mode adds the address to the base of the wavefront. An address that falls outside what its mode may reach raises an error flag. The translation is combinational, and a parameter selects whether a register stage follows it.

Top module: `rf_row_mapper`

## Requirements
- R1: With the default registered output, `out_valid` equals `req_valid` from one clock earlier, and the result fields are registered with that same latency. Reset clears `out_valid`.
- R2: In absolute mode (`req_mode`=1), let S be `cfg_shared_rows`. An address A < S maps to row A with `out_region`=0 (shared).
- R3: In the global modes (1 and 2), let T be `cfg_temp_rows`. An effective address E with S <= E < S+T maps to row E on an even wavefront and to row E+T on an odd wavefront, with `out_region`=1 (temporary). The parity is taken from bit 0 of `req_wave`.
- R4: In a global mode, an effective address E >= S+T sets `out_err`.
- R5: In indexed mode (`req_mode`=2), E is `req_addr` plus `idx_reg` when `req_use_idx`=1, and plus `req_imm_ofs` when `req_use_idx`=0. If E crosses from the shared rows into the temporary rows, no error is raised. A sum of at least the row count sets `out_err`.
- R6: Any global mode with `cfg_dyn_en`=0 sets `out_err`.
- R7: Any global mode with S+2T greater than the row count sets `out_err`. A sum of exactly the row count is legal.
- R8: In private mode (`req_mode`=0), the row is `priv_base`+`req_addr` with `out_region`=2 (private). The error is raised if `req_addr` >= `priv_size`, if the sum is at least the row count, or if `priv_base` < S+2T.
- R9: Mode value 3 is reserved and always sets `out_err`.
- R10: Whenever `out_err` is set, `out_row` is 0 and `out_region` is 3 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | An operand is presented this cycle |
| req_mode | input | 2 | 0 private, 1 absolute, 2 indexed, 3 reserved |
| req_addr | input | 7 | Operand register address |
| req_wave | input | 4 | Wavefront number |
| req_use_idx | input | 1 | Indexed offset source: 1 index register, 0 instruction |
| req_imm_ofs | input | 7 | Offset carried by the instruction |
| idx_reg | input | 7 | Index register value |
| priv_base | input | 7 | First private row of the wavefront |
| priv_size | input | 8 | Number of private rows of the wavefront |
| cfg_shared_rows | input | 8 | Size S of the shared region |
| cfg_temp_rows | input | 8 | Size T of one temporary copy |
| cfg_dyn_en | input | 1 | Dynamic allocation enabled; global modes need it |
| out_valid | output | 1 | Result valid |
| out_row | output | 7 | Physical row |
| out_region | output | 2 | 0 shared, 1 temporary, 2 private, 3 none |
| out_err | output | 1 | Illegal address |

## Verification
The bench uses the default parameters: 128 rows, 16 wavefronts and a registered output. These values make the exact-fit case S+2T=128 and the indexed sum overflowing past row 127 reachable, and they also let the bench probe wavefront parity on both even and odd numbers. Directed cases cover each region edge. After them, a random mix of sizes, modes and offsets lets the shared-to-temporary crossing and the private base overlap arise under many configurations.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

   typedef enum logic [1:0] {
      MODE_PRIV = 2'd0,
      MODE_ABS  = 2'd1,
      MODE_IDX  = 2'd2,
      MODE_RSVD = 2'd3
   } rfm_mode_e;

   typedef enum logic [1:0] {
      RGN_SHARED = 2'd0,
      RGN_TEMP   = 2'd1,
      RGN_PRIV   = 2'd2,
      RGN_NONE   = 2'd3
   } rfm_region_e;

endpackage

// File: rtl/rfm_bounds.sv
// Region boundaries derived from the configured sizes.
module rfm_bounds #(
   parameter int NUM_ROWS = 128,
   localparam int ROW_W = $clog2(NUM_ROWS),
   localparam int XW = ROW_W + 3
) (
   input  logic [ROW_W:0]  shared_rows,
   input  logic [ROW_W:0]  temp_rows,
   output logic [XW-1:0]   temp_lo,
   output logic [XW-1:0]   temp_hi,
   output logic [XW-1:0]   priv_lo,
   output logic            cfg_bad
);
   always_comb begin
      temp_lo = XW'(shared_rows);
      temp_hi = XW'(shared_rows) + XW'(temp_rows);
      priv_lo = temp_hi + XW'(temp_rows);
      cfg_bad = (priv_lo > XW'(NUM_ROWS));
   end
endmodule

// File: rtl/rfm_global_path.sv
// Absolute and indexed translation into the shared and temporary rows.
module rfm_global_path
   import rfm_pkg::*;
#(
   parameter int NUM_ROWS = 128,
   localparam int ROW_W = $clog2(NUM_ROWS),
   localparam int XW = ROW_W + 3
) (
   input  rfm_mode_e        mode,
   input  logic [ROW_W-1:0] addr,
   input  logic             wave_odd,
   input  logic             use_idx,
   input  logic [ROW_W-1:0] imm_ofs,
   input  logic [ROW_W-1:0] idx_val,
   input  logic             dyn_en,
   input  logic             cfg_bad,
   input  logic [XW-1:0]    temp_lo,
   input  logic [XW-1:0]    temp_hi,
   input  logic [ROW_W-1:0] temp_rows,
   output logic [ROW_W-1:0] row,
   output rfm_region_e      region,
   output logic             err
);
   logic [ROW_W-1:0] ofs;
   logic [XW-1:0]    eff;

   always_comb begin
      ofs = '0;
      if (mode == MODE_IDX) ofs = use_idx ? idx_val : imm_ofs;
      eff = XW'(addr) + XW'(ofs);
   end

   always_comb begin
      row    = '0;
      region = RGN_NONE;
      err    = 1'b0;
      if (!dyn_en || cfg_bad || eff >= XW'(NUM_ROWS)) begin
         err = 1'b1;
      end else if (eff < temp_lo) begin
         row    = eff[ROW_W-1:0];
         region = RGN_SHARED;
      end else if (eff < temp_hi) begin
         row    = eff[ROW_W-1:0] + (wave_odd ? temp_rows : '0);
         region = RGN_TEMP;
      end else begin
         err = 1'b1;
      end
   end
endmodule

// File: rtl/rfm_priv_path.sv
// Wavefront-relative translation into the private rows.
module rfm_priv_path
   import rfm_pkg::*;
#(
   parameter int NUM_ROWS = 128,
   localparam int ROW_W = $clog2(NUM_ROWS),
   localparam int XW = ROW_W + 3
) (
   input  logic [ROW_W-1:0] addr,
   input  logic [ROW_W-1:0] base,
   input  logic [ROW_W:0]   size,
   input  logic [XW-1:0]    priv_lo,
   output logic [ROW_W-1:0] row,
   output rfm_region_e      region,
   output logic             err
);
   logic [XW-1:0] sum;

   always_comb begin
      sum    = XW'(base) + XW'(addr);
      row    = '0;
      region = RGN_NONE;
      err    = 1'b0;
      if (XW'(addr) >= XW'(size) || sum >= XW'(NUM_ROWS) || XW'(base) < priv_lo) begin
         err = 1'b1;
      end else begin
         row    = base + addr;
         region = RGN_PRIV;
      end
   end
endmodule

// File: rtl/rfm_out_stage.sv
// Optional register stage on the mapped result.
module rfm_out_stage
   import rfm_pkg::*;
#(
   parameter int ROW_W   = 7,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [ROW_W-1:0] in_row,
   input  rfm_region_e      in_region,
   input  logic             in_err,
   output logic             out_valid,
   output logic [ROW_W-1:0] out_row,
   output rfm_region_e      out_region,
   output logic             out_err
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid  <= 1'b0;
               out_row    <= '0;
               out_region <= RGN_NONE;
               out_err    <= 1'b0;
            end else begin
               out_valid  <= in_valid;
               out_row    <= in_row;
               out_region <= in_region;
               out_err    <= in_err;
            end
         end

         // R1
         lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         // R1
         lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
      end else begin : g_comb
         always_comb begin
            out_valid  = in_valid;
            out_row    = in_row;
            out_region = in_region;
            out_err    = in_err;
         end
      end
   endgenerate

   // R10
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_row == '0 && out_region == RGN_NONE));
endmodule

// File: rtl/rf_row_mapper.sv
module rf_row_mapper
   import rfm_pkg::*;
#(
   parameter int NUM_ROWS  = 128,
   parameter int NUM_WAVES = 16,
   parameter bit REG_OUT   = 1'b1,
   localparam int ROW_W  = $clog2(NUM_ROWS),
   localparam int WAVE_W = $clog2(NUM_WAVES),
   localparam int XW     = ROW_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_mode,
   input  logic [ROW_W-1:0]  req_addr,
   input  logic [WAVE_W-1:0] req_wave,
   input  logic              req_use_idx,
   input  logic [ROW_W-1:0]  req_imm_ofs,
   input  logic [ROW_W-1:0]  idx_reg,
   input  logic [ROW_W-1:0]  priv_base,
   input  logic [ROW_W:0]    priv_size,
   input  logic [ROW_W:0]    cfg_shared_rows,
   input  logic [ROW_W:0]    cfg_temp_rows,
   input  logic              cfg_dyn_en,
   output logic              out_valid,
   output logic [ROW_W-1:0]  out_row,
   output logic [1:0]        out_region,
   output logic              out_err
);
   generate
      if (NUM_ROWS < 8 || (1 << ROW_W) != NUM_ROWS) begin : g_bad_rows
         $error("rf_row_mapper: NUM_ROWS must be a power of two of at least 8");
      end
      if (NUM_WAVES < 2 || (1 << WAVE_W) != NUM_WAVES) begin : g_bad_waves
         $error("rf_row_mapper: NUM_WAVES must be a power of two of at least 2");
      end
   endgenerate

   rfm_mode_e        mode;
   logic [XW-1:0]    temp_lo, temp_hi, priv_lo;
   logic             cfg_bad;
   logic [ROW_W-1:0] g_row, p_row, res_row;
   rfm_region_e      g_region, p_region, res_region, st_region;
   logic             g_err, p_err, res_err;

   assign mode = rfm_mode_e'(req_mode);

   rfm_bounds #(.NUM_ROWS(NUM_ROWS)) bounds_i (
      .shared_rows (cfg_shared_rows),
      .temp_rows   (cfg_temp_rows),
      .temp_lo     (temp_lo),
      .temp_hi     (temp_hi),
      .priv_lo     (priv_lo),
      .cfg_bad     (cfg_bad)
   );

   rfm_global_path #(.NUM_ROWS(NUM_ROWS)) glob_i (
      .mode      (mode),
      .addr      (req_addr),
      .wave_odd  (req_wave[0]),
      .use_idx   (req_use_idx),
      .imm_ofs   (req_imm_ofs),
      .idx_val   (idx_reg),
      .dyn_en    (cfg_dyn_en),
      .cfg_bad   (cfg_bad),
      .temp_lo   (temp_lo),
      .temp_hi   (temp_hi),
      .temp_rows (cfg_temp_rows[ROW_W-1:0]),
      .row       (g_row),
      .region    (g_region),
      .err       (g_err)
   );

   rfm_priv_path #(.NUM_ROWS(NUM_ROWS)) priv_i (
      .addr    (req_addr),
      .base    (priv_base),
      .size    (priv_size),
      .priv_lo (priv_lo),
      .row     (p_row),
      .region  (p_region),
      .err     (p_err)
   );

   always_comb begin
      res_row    = '0;
      res_region = RGN_NONE;
      res_err    = 1'b1;
      unique case (mode)
         MODE_PRIV: begin
            res_row = p_row; res_region = p_region; res_err = p_err;
         end
         MODE_ABS, MODE_IDX: begin
            res_row = g_row; res_region = g_region; res_err = g_err;
         end
         default: begin
            res_err = 1'b1;
         end
      endcase
   end

   rfm_out_stage #(.ROW_W(ROW_W), .REG_OUT(REG_OUT)) out_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (req_valid),
      .in_row     (res_row),
      .in_region  (res_region),
      .in_err     (res_err),
      .out_valid  (out_valid),
      .out_row    (out_row),
      .out_region (st_region),
      .out_err    (out_err)
   );

   assign out_region = st_region;

   // R2
   shared_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !res_err && res_region == RGN_SHARED) |->
         (XW'(res_row) < XW'(cfg_shared_rows) && mode != MODE_PRIV));
   // R3
   temp_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !res_err && res_region == RGN_TEMP) |->
         (XW'(res_row) >= temp_lo && XW'(res_row) < priv_lo &&
          ((XW'(res_row) >= temp_hi) == req_wave[0])));
   // R8
   priv_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !res_err && res_region == RGN_PRIV) |->
         (XW'(res_row) >= priv_lo && mode == MODE_PRIV));
   // R6
   dyn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cfg_dyn_en && (mode == MODE_ABS || mode == MODE_IDX)) |-> res_err);
   // R9
   rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == MODE_RSVD) |-> res_err);
endmodule

// File: tb/rf_row_mapper_tb_top.sv
module rf_row_mapper_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_mode = 2'd0;
   logic [6:0] req_addr = '0;
   logic [3:0] req_wave = '0;
   logic       req_use_idx = 1'b0;
   logic [6:0] req_imm_ofs = '0;
   logic [6:0] idx_reg = '0;
   logic [6:0] priv_base = '0;
   logic [7:0] priv_size = '0;
   logic [7:0] cfg_shared_rows = 8'd16;
   logic [7:0] cfg_temp_rows = 8'd8;
   logic       cfg_dyn_en = 1'b1;
   logic       out_valid;
   logic [6:0] out_row;
   logic [1:0] out_region;
   logic       out_err;

   int    n_checks = 0;
   int    n_fails = 0;
   string cur_tag = "R1 reset";
   string exp_tag = "R1 reset";
   bit    exp_v = 1'b0;
   int    exp_row = 0;
   int    exp_rgn = 3;
   int    exp_err = 0;
   bit    running = 1'b0;
   bit    finished = 1'b0;

   always #5 clk = ~clk;

   rf_row_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_addr(req_addr), .req_wave(req_wave), .req_use_idx(req_use_idx),
      .req_imm_ofs(req_imm_ofs), .idx_reg(idx_reg), .priv_base(priv_base),
      .priv_size(priv_size), .cfg_shared_rows(cfg_shared_rows),
      .cfg_temp_rows(cfg_temp_rows), .cfg_dyn_en(cfg_dyn_en),
      .out_valid(out_valid), .out_row(out_row), .out_region(out_region),
      .out_err(out_err)
   );

   function automatic void ref_map(input int mode, addr, wave, use_idx, imm, idx,
                                   base, size, s, t, dyn,
                                   output int row, output int rgn, output int err);
      int e;
      row = 0; rgn = 3; err = 1;
      if (mode == 0) begin
         if (addr < size && base + addr < 128 && base >= s + 2 * t) begin
            row = base + addr; rgn = 2; err = 0;
         end
      end else if (mode == 1 || mode == 2) begin
         e = addr + ((mode == 2) ? (use_idx ? idx : imm) : 0);
         if (dyn != 0 && s + 2 * t <= 128 && e < 128) begin
            if (e < s) begin
               row = e; rgn = 0; err = 0;
            end else if (e < s + t) begin
               row = e + ((wave % 2) ? t : 0); rgn = 1; err = 0;
            end
         end
      end
   endfunction

   // reference model, one register of latency
   always @(posedge clk) begin
      int r, g, e;
      if (!rst_n) begin
         exp_v <= 1'b0;
      end else begin
         ref_map(req_mode, req_addr, req_wave, req_use_idx, req_imm_ofs, idx_reg,
                 priv_base, priv_size, cfg_shared_rows, cfg_temp_rows, cfg_dyn_en,
                 r, g, e);
         exp_v   <= req_valid;
         exp_row <= r;
         exp_rgn <= g;
         exp_err <= e;
         exp_tag <= cur_tag;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (running && rst_n) begin
         n_checks++;
         if (out_valid !== exp_v) begin
            n_fails++;
            $display("FAIL %s: out_valid=%0d expected %0d", exp_tag, out_valid, exp_v);
         end else if (exp_v) begin
            if (out_err !== exp_err[0] || int'(out_row) != exp_row || int'(out_region) != exp_rgn) begin
               n_fails++;
               $display("FAIL %s: row=%0d rgn=%0d err=%0d expected row=%0d rgn=%0d err=%0d",
                        exp_tag, out_row, out_region, out_err, exp_row, exp_rgn, exp_err);
            end
         end
      end
   end

   task automatic op(input string tag, input int mode, input int addr, input int wave,
                     input int use_idx = 0, input int imm = 0, input int idx = 0,
                     input int base = 0, input int size = 0);
      @(negedge clk);
      cur_tag     = tag;
      req_valid   = 1'b1;
      req_mode    = 2'(mode);
      req_addr    = 7'(addr);
      req_wave    = 4'(wave);
      req_use_idx = use_idx[0];
      req_imm_ofs = 7'(imm);
      idx_reg     = 7'(idx);
      priv_base   = 7'(base);
      priv_size   = 8'(size);
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      cur_tag   = tag;
      req_valid = 1'b0;
   endtask

   task automatic set_cfg(input int s, input int t, input int dyn);
      @(negedge clk);
      req_valid       = 1'b0;
      cur_tag         = "R1 cfg idle";
      cfg_shared_rows = 8'(s);
      cfg_temp_rows   = 8'(t);
      cfg_dyn_en      = dyn[0];
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0) begin
         n_fails++;
         $display("FAIL R1 reset: out_valid=%0d expected 0", out_valid);
      end
      rst_n   = 1'b1;
      running = 1'b1;

      set_cfg(16, 8, 1);
      op("R2 shared low", 1, 5, 0);
      op("R2 shared top", 1, 15, 3);
      op("R3 temp even", 1, 16, 2);
      op("R3 temp odd", 1, 16, 3);
      op("R3 temp odd top", 1, 23, 1);
      op("R4 past temp", 1, 24, 0);
      op("R4 far", 1, 100, 5);
      idle("R1 idle");
      op("R5 imm", 2, 10, 0, 0, 3, 60);
      op("R5 idx cross", 2, 10, 0, 1, 60, 10);
      op("R5 idx cross odd", 2, 10, 7, 1, 60, 10);
      op("R5 imm into temp", 2, 20, 0, 0, 2, 0);
      op("R5 overflow", 2, 120, 0, 1, 0, 10);
      op("R5 sum 127", 2, 100, 0, 1, 0, 27);
      op("R8 priv ok", 0, 19, 4, 0, 0, 0, 40, 20);
      op("R8 priv size", 0, 20, 4, 0, 0, 0, 40, 20);
      op("R8 priv overlap", 0, 0, 4, 0, 0, 0, 31, 20);
      op("R8 priv edge", 0, 0, 4, 0, 0, 0, 32, 20);
      op("R8 priv wrap", 0, 10, 4, 0, 0, 0, 120, 20);
      op("R9 reserved", 3, 5, 0);
      set_cfg(16, 8, 0);
      op("R6 dyn off abs", 1, 5, 0);
      op("R6 dyn off idx", 2, 5, 0, 0, 1, 0);
      op("R6 priv unaffected", 0, 3, 0, 0, 0, 0, 40, 8);
      set_cfg(100, 16, 1);
      op("R7 oversize", 1, 5, 0);
      set_cfg(96, 16, 1);
      op("R7 exact fit", 1, 5, 0);
      op("R7 exact fit temp odd", 1, 100, 1);
      op("R10 error clears", 1, 127, 1);
      idle("R1 idle");

      for (int i = 0; i < 3000; i++) begin
         if (i % 50 == 0) set_cfg($urandom_range(0, 70), $urandom_range(0, 40),
                                  ($urandom_range(0, 9) != 0) ? 1 : 0);
         if ($urandom_range(0, 7) == 0) idle("R1 random idle");
         else op("R5 R8 random", $urandom_range(0, 3), $urandom_range(0, 127),
                 $urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 127),
                 $urandom_range(0, 127), $urandom_range(0, 127), $urandom_range(0, 128));
      end
      idle("R1 drain");
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule